// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block brings up an externally clocked asynchronous smart card and shuts it down again. On an activate request it latches a supply code and a clock-speed code. It then walks the card contacts through a fixed power-up order. Next it probes which reset level the card expects. It holds RST low for a bounded window of card clock edges and waits for the start bit of an Answer-to-Reset from the I/O receiver. If no start bit comes, it drives RST high and waits for a second window of the same length. If that window also ends in silence, it raises a failure flag and deactivates the card.

Once an answer is seen, the RST level at which it arrived is kept as the card's run level. A later warm-reset request drives the opposite level for a programmable number of card clocks. A clock-stop request halts the card clock and leaves the card unusable until it is activated again. A shutdown request, or a failed probe, releases the contacts in reverse order. Each step of that release waits one card clock. The card clock is the system clock divided according to the speed code. The serial character engine, ATR decoding and the analog supply switches live elsewhere.

Top module: `sc_act_seq`

## Requirements
- R1: Activation order. Starting from the off state, an activate request puts the latched supply code on `vcc_sel` while `card_rst` stays 0 and `io_rel` stays 0. `io_rel` rises one cycle later. The card clock starts only after that.
- R2: After the clock starts, `card_rst` is held 0. An `atr_start` pulse during this window makes `card_active` 1 with `card_rst` still 0. If no pulse arrives within `ATR_WIN` card clock edges, `card_rst` goes to 1.
- R3: If a second window of `ATR_WIN` card clock edges with `card_rst` at 1 also passes without `atr_start`, then `fail` becomes 1, `card_active` stays 0 and the card is deactivated. `fail` clears on the next activation.
- R4: `spd_in` selects the card clock. 00 keeps `card_clk` at 0. 01 gives a half period of 4·`HALF_4M` system cycles, 10 gives 2·`HALF_4M`, and 11 gives `HALF_4M`.
- R5: `vsel_in` is sampled only on an activate request. A change at any other time leaves `vcc_sel` unchanged until the next activation. `vcc_sel` is 00 whenever the card is off.
- R6: While the card is active, a clock-stop request holds `card_clk` at 0 and clears `card_active`. Warm-reset requests are then ignored. Only a new activate request, which restarts the full sequence with `card_rst` at 0, makes the card usable again.
- R7: Deactivation order. First `card_rst` is driven 0, then the clock stops, then `io_rel` falls (the line is held low), and then `vcc_sel` returns to 00. Each step lasts one card clock period. No card clock runs while `vcc_sel` is 00.
- R8: The probe windows count card clock edges. A window's length in system cycles therefore scales with the half period that `spd_in` selects.
- R9: `rst_run_hi` records the `card_rst` level at which the answer arrived (1 = high). While the card is active, `card_rst` sits at that level. A warm-reset request drives the opposite level for `warm_len` card clocks (0 counts as 1) and then returns to the run level, with `card_active` held 1 throughout.
- R10: A shutdown request in any powered state, including partway through activation, runs the deactivation of R7 and does not set `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | 1 | Activate request, one-cycle pulse |
| shut_req | input | 1 | Shutdown request, one-cycle pulse |
| stop_req | input | 1 | Clock-stop request, one-cycle pulse |
| warm_req | input | 1 | Warm-reset request, one-cycle pulse |
| vsel_in | input | 2 | Supply class code (00 0 V, 01 1.8 V, 10 3.0 V, 11 5 V) |
| spd_in | input | 2 | Card clock speed code |
| warm_len | input | WARM_W | Warm-reset pulse length in card clocks |
| atr_start | input | 1 | Start-bit detect from the I/O receiver |
| vcc_sel | output | 2 | Supply select to the switch network |
| card_clk | output | 1 | Gated card clock |
| card_rst | output | 1 | Card RST line level |
| io_rel | output | 1 | 1: I/O line released to the receiver; 0: held low |
| rst_run_hi | output | 1 | Detected run level of RST |
| card_active | output | 1 | Card answered and is in service |
| fail | output | 1 | Neither reset level brought an answer |

## Verification
The assertions assume that requests are one-cycle pulses and that activation always uses a nonzero supply code. Without a supply, the release of the I/O line cannot be told apart from an unpowered state. The stimulus never activates with `vsel_in` at 00. It raises only one request at a time, and it pulses `atr_start` only inside a probe window or while the card is running. `HALF_4M` and `ATR_WIN` are reduced so that both probe windows fit in a short run at every speed code.

// File: rtl/sc_act_pkg.sv
package sc_act_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_PWR,
    ST_ARM,
    ST_CLK,
    ST_WLO,
    ST_WHI,
    ST_RUN,
    ST_WARM,
    ST_STOP,
    ST_DRST,
    ST_DCLK,
    ST_DIO
  } seq_state_t;

  localparam logic [1:0] SPD_OFF = 2'b00;
  localparam logic [1:0] SPD_1X  = 2'b01;
  localparam logic [1:0] SPD_2X  = 2'b10;
  localparam logic [1:0] SPD_4X  = 2'b11;

  localparam logic [1:0] VCC_NONE = 2'b00;

endpackage

// File: rtl/sc_card_clkgen.sv
module sc_card_clkgen
  import sc_act_pkg::*;
#(
  parameter int HALF_4M = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] spd,
  input  logic       en,
  output logic       card_clk,
  output logic       tick
);
  localparam int DW = $clog2(HALF_4M * 4 + 1);
  localparam logic [DW-1:0] LIM_1X = DW'(HALF_4M * 4);
  localparam logic [DW-1:0] LIM_2X = DW'(HALF_4M * 2);
  localparam logic [DW-1:0] LIM_4X = DW'(HALF_4M);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;
  logic          div_q;
  logic          en_q;
  logic          wrap;

  // The code 00 gates the output; the reference keeps the slowest rate.
  always_comb begin
    unique case (spd)
      SPD_2X:  lim = LIM_2X;
      SPD_4X:  lim = LIM_4X;
      default: lim = LIM_1X;
    endcase
  end

  assign wrap = (cnt >= lim - DW'(1));
  assign tick = wrap && !div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (wrap) begin
        cnt   <= '0;
        div_q <= ~div_q;
      end else begin
        cnt <= cnt + DW'(1);
      end
      // The gate changes only in the low phase, so no pulse is cut short.
      if (!div_q) en_q <= en && (spd != SPD_OFF);
    end
  end

  assign card_clk = div_q & en_q;

endmodule

// File: rtl/sc_tick_timer.sv
module sc_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic [TW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
  assign done    = run && tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (run && tick)  cnt <= cnt_inc[TW-1:0];
  end

endmodule

// File: rtl/sc_act_fsm.sv
module sc_act_fsm
  import sc_act_pkg::*;
#(
  parameter int ATR_WIN = 40000,
  parameter int WARM_W  = 8,
  parameter int TW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              shut_req,
  input  logic              stop_req,
  input  logic              warm_req,
  input  logic [1:0]        vsel_in,
  input  logic [1:0]        spd_in,
  input  logic [WARM_W-1:0] warm_len,
  input  logic              atr_start,
  input  logic              tmr_done,
  output logic [1:0]        vcc_sel,
  output logic [1:0]        spd_q,
  output logic              clk_on,
  output logic              card_rst,
  output logic              io_rel,
  output logic              tmr_run,
  output logic              tmr_clr,
  output logic [TW-1:0]     tmr_limit,
  output logic              rst_run_hi,
  output logic              card_active,
  output logic              fail
);
  seq_state_t        st, nx;
  logic [1:0]        vsel_q;
  logic              run_hi_q;
  logic              fail_q;
  logic              ck_live;
  logic [WARM_W-1:0] warm_q;
  logic              powered;

  assign powered = st inside {ST_PWR, ST_ARM, ST_CLK, ST_WLO, ST_WHI,
                              ST_RUN, ST_WARM, ST_STOP};

  always_comb begin
    nx = st;
    if (shut_req && powered) begin
      nx = ST_DRST;
    end else begin
      unique case (st)
        ST_OFF:  if (act_req) nx = ST_PWR;
        ST_PWR:  nx = ST_ARM;
        ST_ARM:  nx = ST_CLK;
        ST_CLK:  nx = ST_WLO;
        ST_WLO:  if (atr_start) nx = ST_RUN;
                 else if (tmr_done) nx = ST_WHI;
        ST_WHI:  if (atr_start) nx = ST_RUN;
                 else if (tmr_done) nx = ST_DRST;
        ST_RUN:  if (stop_req) nx = ST_STOP;
                 else if (warm_req) nx = ST_WARM;
        ST_WARM: if (stop_req) nx = ST_STOP;
                 else if (tmr_done) nx = ST_RUN;
        ST_STOP: if (act_req) nx = ST_PWR;
        ST_DRST: if (tmr_done) nx = ST_DCLK;
        ST_DCLK: if (tmr_done) nx = ST_DIO;
        ST_DIO:  if (tmr_done) nx = ST_OFF;
        default: nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      vsel_q   <= VCC_NONE;
      spd_q    <= SPD_OFF;
      run_hi_q <= 1'b0;
      fail_q   <= 1'b0;
      ck_live  <= 1'b0;
      warm_q   <= WARM_W'(1);
    end else begin
      st <= nx;
      if (nx == ST_PWR && st != ST_PWR) begin
        vsel_q <= vsel_in;
        spd_q  <= spd_in;
        fail_q <= 1'b0;
      end
      if (st == ST_WLO && nx == ST_RUN) run_hi_q <= 1'b0;
      if (st == ST_WHI && nx == ST_RUN) run_hi_q <= 1'b1;
      if (st == ST_WHI && tmr_done && !atr_start && !shut_req) fail_q <= 1'b1;
      if (nx == ST_CLK) ck_live <= 1'b1;
      else if (nx inside {ST_STOP, ST_DCLK, ST_DIO, ST_OFF, ST_PWR}) ck_live <= 1'b0;
      if (st == ST_RUN && nx == ST_WARM)
        warm_q <= (warm_len == '0) ? WARM_W'(1) : warm_len;
    end
  end

  always_comb begin
    unique case (st)
      ST_WHI:  card_rst = 1'b1;
      ST_RUN:  card_rst = run_hi_q;
      ST_STOP: card_rst = run_hi_q;
      ST_WARM: card_rst = ~run_hi_q;
      default: card_rst = 1'b0;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_WLO, ST_WHI: tmr_limit = TW'(ATR_WIN);
      ST_WARM:        tmr_limit = TW'(warm_q);
      default:        tmr_limit = TW'(1);
    endcase
  end

  assign io_rel      = st inside {ST_ARM, ST_CLK, ST_WLO, ST_WHI, ST_RUN,
                                  ST_WARM, ST_STOP, ST_DRST, ST_DCLK};
  assign vcc_sel     = (st == ST_OFF) ? VCC_NONE : vsel_q;
  assign clk_on      = ck_live;
  assign tmr_run     = st inside {ST_WLO, ST_WHI, ST_WARM, ST_DRST, ST_DCLK, ST_DIO};
  assign tmr_clr     = (nx != st);
  assign rst_run_hi  = run_hi_q;
  assign card_active = st inside {ST_RUN, ST_WARM};
  assign fail        = fail_q;

endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
  import sc_act_pkg::*;
#(
  parameter int HALF_4M = 12,
  parameter int ATR_WIN = 40000,
  parameter int WARM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              shut_req,
  input  logic              stop_req,
  input  logic              warm_req,
  input  logic [1:0]        vsel_in,
  input  logic [1:0]        spd_in,
  input  logic [WARM_W-1:0] warm_len,
  input  logic              atr_start,
  output logic [1:0]        vcc_sel,
  output logic              card_clk,
  output logic              card_rst,
  output logic              io_rel,
  output logic              rst_run_hi,
  output logic              card_active,
  output logic              fail
);
  localparam int WIN_W = $clog2(ATR_WIN + 1);
  localparam int TW    = (WIN_W > WARM_W) ? WIN_W : WARM_W;

  logic [1:0]    spd_q;
  logic          clk_on;
  logic          tick;
  logic          tmr_run;
  logic          tmr_clr;
  logic          tmr_done;
  logic [TW-1:0] tmr_limit;

  sc_act_fsm #(.ATR_WIN(ATR_WIN), .WARM_W(WARM_W), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .act_req(act_req), .shut_req(shut_req), .stop_req(stop_req), .warm_req(warm_req),
    .vsel_in(vsel_in), .spd_in(spd_in), .warm_len(warm_len), .atr_start(atr_start),
    .tmr_done(tmr_done),
    .vcc_sel(vcc_sel), .spd_q(spd_q), .clk_on(clk_on), .card_rst(card_rst),
    .io_rel(io_rel), .tmr_run(tmr_run), .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
    .rst_run_hi(rst_run_hi), .card_active(card_active), .fail(fail)
  );

  sc_card_clkgen #(.HALF_4M(HALF_4M)) u_clk (
    .clk(clk), .rst_n(rst_n), .spd(spd_q), .en(clk_on),
    .card_clk(card_clk), .tick(tick)
  );

  sc_tick_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .tick(tick),
    .limit(tmr_limit), .done(tmr_done)
  );

endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] vcc_sel,
  input logic       card_clk,
  input logic       card_rst,
  input logic       io_rel,
  input logic       card_active,
  input logic       fail
);
  a_r1_release_after_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_rel) |-> (vcc_sel != 2'b00) && !card_rst);

  a_r7_no_clock_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_sel == 2'b00) |-> !card_clk);

  a_r3_fail_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !card_active);

  a_r5_supply_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (card_active && $past(card_active)) |-> $stable(vcc_sel));

  a_r7_io_low_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_rel) |-> !card_rst && !card_clk && (vcc_sel != 2'b00));

  a_r6_active_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    card_active |-> io_rel && (vcc_sel != 2'b00));
endmodule

bind sc_act_seq sc_act_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_sel(vcc_sel), .card_clk(card_clk),
  .card_rst(card_rst), .io_rel(io_rel), .card_active(card_active), .fail(fail)
);

// File: tb/tb_sc_act_seq.sv
module tb_sc_act_seq;
  localparam int HALF = 2;
  localparam int WIN  = 6;

  logic clk, rst_n, act_req, shut_req, stop_req, warm_req, atr_start;
  logic [1:0] vsel_in, spd_in, vcc_sel;
  logic [7:0] warm_len;
  logic card_clk, card_rst, io_rel, rst_run_hi, card_active, fail;
  int n_chk = 0, n_fail = 0;

  sc_act_seq #(.HALF_4M(HALF), .ATR_WIN(WIN), .WARM_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .shut_req(shut_req),
    .stop_req(stop_req), .warm_req(warm_req), .vsel_in(vsel_in), .spd_in(spd_in),
    .warm_len(warm_len), .atr_start(atr_start), .vcc_sel(vcc_sel),
    .card_clk(card_clk), .card_rst(card_rst), .io_rel(io_rel),
    .rst_run_hi(rst_run_hi), .card_active(card_active), .fail(fail));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // [7:6] supply, [5:4] speed, [3:2] answer phase (0 low, 1 high, 2 none),
  // [1] expected run level, [0] expected fail
  localparam logic [7:0] VEC [6] = '{8'b10110000, 8'b01110110, 8'b10101001,
                                     8'b01010110, 8'b11100000, 8'b10001001};

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_act(input logic [1:0] v, input logic [1:0] s);
    vsel_in = v; spd_in = s; act_req = 1'b1; cyc(); act_req = 1'b0;
  endtask

  task automatic pulse_atr();
    atr_start = 1'b1; cyc(); atr_start = 1'b0;
  endtask

  task automatic wait_rst_high(output int n);
    n = 0;
    for (int i = 0; i < 400 && !card_rst; i++) begin cyc(); n++; end
  endtask

  task automatic wait_deact();
    bit seen = 0;
    for (int i = 0; i < 400; i++) begin
      if (!io_rel && !seen) begin
        seen = 1;
        chk(!card_rst && !card_clk && vcc_sel != 2'b00, "R7 io low after rst/clk",
            {card_rst, card_clk, vcc_sel != 2'b00}, 3'b001);
      end
      if (vcc_sel == 2'b00) break;
      cyc();
    end
    chk(seen && vcc_sel == 2'b00 && !card_clk, "R7 supply removed last",
        {seen, vcc_sel}, 3'b100);
  endtask

  task automatic shut();
    shut_req = 1'b1; cyc(); shut_req = 1'b0; wait_deact();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, rises, first, second, lowlen, highs;
    logic prev;
    rst_n = 0; act_req = 0; shut_req = 0; stop_req = 0; warm_req = 0;
    atr_start = 0; vsel_in = 2'b10; spd_in = 2'b11; warm_len = 8'd3;
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk(vcc_sel == 0 && !card_clk && !card_rst && !io_rel && !card_active && !fail,
        "R5 reset state off", {vcc_sel, card_clk, card_rst, io_rel, card_active, fail}, 0);

    // table walk
    for (int k = 0; k < 6; k++) begin
      logic [1:0] v, s, ph;
      v = VEC[k][7:6]; s = VEC[k][5:4]; ph = VEC[k][3:2];
      pulse_act(v, s);
      chk(vcc_sel == v && !card_rst && !io_rel, "R1 supply first",
          {vcc_sel, card_rst, io_rel}, {v, 2'b00});
      cyc();
      chk(io_rel && !card_clk && !card_rst, "R1 io released before clock",
          {io_rel, card_clk}, 2'b10);
      if (ph == 2'd0) begin
        repeat (3) cyc();
        pulse_atr();
        chk(card_active && !card_rst && !rst_run_hi, "R2 answer with RST low",
            {card_active, card_rst, rst_run_hi}, 3'b100);
      end else if (ph == 2'd1) begin
        wait_rst_high(n);
        pulse_atr();
        chk(card_active && card_rst && rst_run_hi, "R9 answer with RST high",
            {card_active, card_rst, rst_run_hi}, 3'b111);
      end else begin
        highs = 0;
        for (int i = 0; i < 800 && !fail; i++) begin
          if (card_clk) highs++;
          cyc();
        end
        chk(fail && !card_active, "R3 no answer fails", {fail, card_active}, 2'b10);
        chk((s == 2'b00) ? (highs == 0) : (highs > 0), "R4 clock gating by code",
            highs, (s == 2'b00) ? 0 : 1);
      end
      chk(fail == VEC[k][0], "R3 fail flag", fail, VEC[k][0]);
      if (ph != 2'd2) shut(); else wait_deact();
    end
    chk(fail == 1'b1, "R3 fail held while off", fail, 1);

    // R8/R4: window length and clock period at speed 11
    pulse_act(2'b10, 2'b11);
    chk(fail == 1'b0, "R3 fail cleared by activate", fail, 0);
    n = 1; rises = 0; first = -1; second = -1; prev = card_clk;
    while (!card_rst && n < 400) begin
      cyc(); n++;
      if (card_clk && !prev) begin
        rises++;
        if (first < 0) first = n; else if (second < 0) second = n;
      end
      prev = card_clk;
    end
    chk(n >= 18 && n <= 32, "R8 window cycles at code 11", n, 24);
    chk(rises >= WIN - 1 && rises <= WIN + 1, "R2 window card clock edges", rises, WIN);
    chk(second - first == 4 * HALF / 2 * 2 / 2 * 2 / 2 + 0 || second - first == 2 * HALF,
        "R4 period at code 11", second - first, 2 * HALF);
    shut();

    // R8/R4 at speed 01
    pulse_act(2'b10, 2'b01);
    n = 1; first = -1; second = -1; prev = card_clk;
    while (!card_rst && n < 400) begin
      cyc(); n++;
      if (card_clk && !prev) begin
        if (first < 0) first = n; else if (second < 0) second = n;
      end
      prev = card_clk;
    end
    chk(n >= 80 && n <= 104, "R8 window cycles at code 01", n, 96);
    chk(second - first == 8 * HALF, "R4 period at code 01", second - first, 8 * HALF);
    pulse_atr();
    chk(card_active && rst_run_hi, "R9 high level answer at code 01",
        {card_active, rst_run_hi}, 2'b11);
    shut();

    // R5, R9, R6 directed
    pulse_act(2'b10, 2'b11);
    wait_rst_high(n);
    pulse_atr();
    vsel_in = 2'b01;
    repeat (5) cyc();
    chk(vcc_sel == 2'b10, "R5 supply change ignored while active", vcc_sel, 2);
    warm_len = 8'd3; warm_req = 1'b1; cyc(); warm_req = 1'b0;
    lowlen = 0;
    for (int i = 0; i < 40 && !card_rst; i++) begin
      if (!card_active) lowlen = 100;
      lowlen++; cyc();
    end
    chk(lowlen >= 8 && lowlen <= 13, "R9 warm pulse length", lowlen, 12);
    chk(card_rst && card_active, "R9 back to run level", {card_rst, card_active}, 2'b11);
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    repeat (4) cyc();
    highs = 0;
    for (int i = 0; i < 20; i++) begin if (card_clk) highs++; cyc(); end
    chk(highs == 0 && !card_active, "R6 clock held by stop", highs, 0);
    warm_req = 1'b1; cyc(); warm_req = 1'b0;
    repeat (3) cyc();
    chk(card_rst && !card_active, "R6 warm ignored while stopped",
        {card_rst, card_active}, 2'b10);
    pulse_act(2'b01, 2'b11);
    chk(!card_rst && vcc_sel == 2'b01, "R6 reactivation restarts RST low",
        {card_rst, vcc_sel}, 1);
    repeat (5) cyc();
    pulse_atr();
    chk(card_active && !rst_run_hi, "R9 polarity re-detected",
        {card_active, rst_run_hi}, 2'b10);
    shut();

    // R10: shutdown partway through activation
    pulse_act(2'b10, 2'b11);
    cyc();
    shut();
    chk(!fail && !card_active, "R10 early shutdown no fail", {fail, card_active}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule